// File: doc/BRIEF.md
# Branch Target Cache with Direction History

This block predicts the next fetch address for an instruction fetch unit. It pairs two structures. The first is a small fully associative target cache that records only branches that were taken, each entry holding the branch's word address and its destination. The second is a larger direct-indexed table of 2-bit saturating counters that gives a taken or not-taken direction. Both are searched combinationally with the fetch address in the same cycle. A hit in the target cache steers fetch to the stored destination; a miss steers it to the next sequential word.

A second lookup port serves the decode stage. Decode presents the address of a branch, whether fetch had hit in the target cache for it, and the destination decode computed from the instruction. The direction table then confirms or overrules the fetch-time choice and, on disagreement, gives a corrected address. When a branch resolves, the resolution port trains the counter, installs or refreshes the target entry on a taken outcome, drops the entry on a not-taken outcome, and raises a flush when the direction predicted at fetch turns out wrong.

Top module: `bpred_top`

## Requirements
- R1: After reset no target cache entry is valid, the round-robin pointer is 0 and every direction counter holds 1 (weakly not taken).
- R2: When a valid target entry's tag equals fetch_pc[31:2], fetch_hit is 1 and fetch_next_pc equals that entry's stored target, in the same cycle.
- R3: When no valid entry matches, fetch_hit is 0 and fetch_next_pc equals fetch_pc + 4.
- R4: A taken resolution whose address hits rewrites that entry's target; one that misses writes address and target into the entry named by the round-robin pointer, which then advances by one and wraps from 63 to 0.
- R5: A not-taken resolution whose address hits clears that entry's valid bit and leaves the pointer unchanged; a not-taken miss leaves the target cache untouched.
- R6: Counters are indexed by address bits [10:2]; a taken resolution adds 1 saturating at 3, a not-taken one subtracts 1 saturating at 0; a direction output is 1 exactly when its counter is 2 or 3.
- R7: fetch_taken gives the counter direction at the fetch address; dec_taken gives it at dec_pc.
- R8: dec_override is 1 only when dec_valid is 1 and dec_taken differs from dec_btc_hit; dec_fix_pc is dec_target when dec_taken is 1 and dec_pc + 4 otherwise.
- R9: upd_flush is 1 exactly when upd_valid is 1 and upd_pred_taken differs from upd_taken.
- R10: A resolution and a lookup of the same entry in one cycle: the lookup returns the state held before that resolution, which becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address of the block being fetched |
| fetch_hit | output | 1 | Target cache hit for fetch_pc |
| fetch_next_pc | output | 32 | Predicted next fetch address |
| fetch_taken | output | 1 | Counter direction at fetch_pc |
| dec_valid | input | 1 | Decode check request |
| dec_pc | input | 32 | Address of the branch under decode |
| dec_btc_hit | input | 1 | Whether fetch had hit for this branch |
| dec_target | input | 32 | Destination computed by decode |
| dec_taken | output | 1 | Counter direction at dec_pc |
| dec_override | output | 1 | Decode overrules the fetch-time choice |
| dec_fix_pc | output | 32 | Corrected next address |
| upd_valid | input | 1 | Branch resolution valid |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved destination |
| upd_pred_taken | input | 1 | Direction predicted at fetch for it |
| upd_flush | output | 1 | Younger instructions must be discarded |

## Verification
Every cycle the properties check the sequential fall-through on a miss, that a taken resolution is visible to a fetch of the same address one cycle later, that a not-taken resolution leaves it unfound, that two taken resolutions in a row leave the counter predicting taken, and that override and flush stay low without their valid inputs. Round-robin eviction order after the cache fills, counter saturation at both ends, the old-value view during a same-cycle resolution and long mixed histories with address aliasing in the counter table are only shown by the bench's scenarios against its reference model.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
   typedef enum logic [1:0] {
      CNT_SNT = 2'd0,
      CNT_WNT = 2'd1,
      CNT_WT  = 2'd2,
      CNT_ST  = 2'd3
   } cnt_t;

   function automatic cnt_t cnt_step(cnt_t c, logic taken);
      cnt_t r;
      r = c;
      if (taken && c != CNT_ST)
         r = cnt_t'(c + 2'd1);
      else if (!taken && c != CNT_SNT)
         r = cnt_t'(c - 2'd1);
      return r;
   endfunction

   function automatic logic cnt_dir(cnt_t c);
      return c[1];
   endfunction
endpackage

// File: rtl/bpred_btc.sv
module bpred_btc #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target
);
   localparam int TAG_W = ADDR_W - 2;
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("bpred_btc: ENTRIES must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("bpred_btc: ADDR_W too small");
   end

   logic [ENTRIES-1:0] vld;
   logic [TAG_W-1:0]   tag [ENTRIES];
   logic [ADDR_W-1:0]  tgt [ENTRIES];
   logic [PTR_W-1:0]   ptr;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] up_match;
   logic               up_hit;
   logic [PTR_W-1:0]   up_idx;
   logic               alloc;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign lk_match[i] = vld[i] && (tag[i] == lk_pc[ADDR_W-1:2]);
      assign up_match[i] = vld[i] && (tag[i] == up_pc[ADDR_W-1:2]);
   end

   always_comb begin
      lk_hit    = |lk_match;
      lk_target = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (lk_match[i]) lk_target = tgt[i];
   end

   always_comb begin
      up_hit = |up_match;
      up_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (up_match[i]) up_idx = PTR_W'(i);
   end

   assign alloc = up_valid && up_taken && !up_hit;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic wr_here;
      assign wr_here = up_valid && up_taken &&
                       ((up_hit && up_idx == PTR_W'(i)) ||
                        (!up_hit && ptr == PTR_W'(i)));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[i] <= 1'b0;
            tag[i] <= '0;
            tgt[i] <= '0;
         end else if (wr_here) begin
            vld[i] <= 1'b1;
            tag[i] <= up_pc[ADDR_W-1:2];
            tgt[i] <= up_target;
         end else if (up_valid && !up_taken && up_match[i]) begin
            vld[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (alloc)
         ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/bpred_bht.sv
module bpred_bht
   import bpred_pkg::*;
#(
   parameter int ENTRIES = 512,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] fa_idx,
   output logic             fa_taken,
   input  logic [IDX_W-1:0] da_idx,
   output logic             da_taken,
   input  logic             up_valid,
   input  logic [IDX_W-1:0] up_idx,
   input  logic             up_taken
);
   if ((1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("bpred_bht: ENTRIES must be a power of two");
   end

   cnt_t cnt [ENTRIES];

   assign fa_taken = cnt_dir(cnt[fa_idx]);
   assign da_taken = cnt_dir(cnt[da_idx]);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt[i] <= CNT_WNT;
         else if (up_valid && up_idx == IDX_W'(i))
            cnt[i] <= cnt_step(cnt[i], up_taken);
      end
   end
endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
   parameter int ADDR_W      = 32,
   parameter int BTC_ENTRIES = 64,
   parameter int BHT_ENTRIES = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              fetch_hit,
   output logic [ADDR_W-1:0] fetch_next_pc,
   output logic              fetch_taken,
   input  logic              dec_valid,
   input  logic [ADDR_W-1:0] dec_pc,
   input  logic              dec_btc_hit,
   input  logic [ADDR_W-1:0] dec_target,
   output logic              dec_taken,
   output logic              dec_override,
   output logic [ADDR_W-1:0] dec_fix_pc,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              upd_pred_taken,
   output logic              upd_flush
);
   localparam int IDX_W = $clog2(BHT_ENTRIES);
   localparam logic [ADDR_W-1:0] WORD = ADDR_W'(4);

   if (ADDR_W < IDX_W + 2) begin : g_bad_index
      $error("bpred_top: address too narrow for the history index");
   end

   logic [ADDR_W-1:0] btc_target;

   bpred_btc #(.ADDR_W(ADDR_W), .ENTRIES(BTC_ENTRIES)) u_btc (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_pc     (fetch_pc),
      .lk_hit    (fetch_hit),
      .lk_target (btc_target),
      .up_valid  (upd_valid),
      .up_pc     (upd_pc),
      .up_taken  (upd_taken),
      .up_target (upd_target)
   );

   bpred_bht #(.ENTRIES(BHT_ENTRIES), .IDX_W(IDX_W)) u_bht (
      .clk      (clk),
      .rst_n    (rst_n),
      .fa_idx   (fetch_pc[IDX_W+1:2]),
      .fa_taken (fetch_taken),
      .da_idx   (dec_pc[IDX_W+1:2]),
      .da_taken (dec_taken),
      .up_valid (upd_valid),
      .up_idx   (upd_pc[IDX_W+1:2]),
      .up_taken (upd_taken)
   );

   assign fetch_next_pc = fetch_hit ? btc_target : fetch_pc + WORD;
   assign dec_override  = dec_valid && (dec_taken != dec_btc_hit);
   assign dec_fix_pc    = dec_taken ? dec_target : dec_pc + WORD;
   assign upd_flush     = upd_valid && (upd_pred_taken != upd_taken);
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
   parameter int ADDR_W      = 32,
   parameter int BHT_ENTRIES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              fetch_hit,
   input logic [ADDR_W-1:0] fetch_next_pc,
   input logic              dec_valid,
   input logic [ADDR_W-1:0] dec_pc,
   input logic              dec_taken,
   input logic              dec_override,
   input logic              upd_valid,
   input logic [ADDR_W-1:0] upd_pc,
   input logic              upd_taken,
   input logic [ADDR_W-1:0] upd_target,
   input logic              upd_flush
);
   localparam int IX = $clog2(BHT_ENTRIES);

   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_miss_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_hit |-> fetch_next_pc == fetch_pc + ADDR_W'(4));

   assert_taken_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(upd_valid && upd_taken) && fetch_pc == $past(upd_pc))
      |-> (fetch_hit && fetch_next_pc == $past(upd_target)));

   assert_nottaken_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && $past(upd_valid && !upd_taken) && fetch_pc == $past(upd_pc))
      |-> !fetch_hit);

   assert_two_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2 && dec_valid &&
       $past(upd_valid && upd_taken, 1) && $past(upd_valid && upd_taken, 2) &&
       $past(upd_pc[IX+1:2], 1) == $past(upd_pc[IX+1:2], 2) &&
       dec_pc[IX+1:2] == $past(upd_pc[IX+1:2], 1))
      |-> dec_taken);

   assert_override_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_override);

   assert_flush_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |-> !upd_flush);
endmodule

bind bpred_top bpred_chk #(.ADDR_W(ADDR_W), .BHT_ENTRIES(BHT_ENTRIES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fetch_pc      (fetch_pc),
   .fetch_hit     (fetch_hit),
   .fetch_next_pc (fetch_next_pc),
   .dec_valid     (dec_valid),
   .dec_pc        (dec_pc),
   .dec_taken     (dec_taken),
   .dec_override  (dec_override),
   .upd_valid     (upd_valid),
   .upd_pc        (upd_pc),
   .upd_taken     (upd_taken),
   .upd_target    (upd_target),
   .upd_flush     (upd_flush)
);

// File: tb/tb_bpred_top.sv
module tb_bpred_top;
   localparam int NB = 64;
   localparam int NH = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_hit;
   logic [31:0] fetch_next_pc;
   logic        fetch_taken;
   logic        dec_valid = 1'b0;
   logic [31:0] dec_pc = '0;
   logic        dec_btc_hit = 1'b0;
   logic [31:0] dec_target = '0;
   logic        dec_taken;
   logic        dec_override;
   logic [31:0] dec_fix_pc;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        upd_pred_taken = 1'b0;
   logic        upd_flush;

   bpred_top dut (.*);

   always #4ns clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   logic        m_vld [NB];
   logic [29:0] m_tag [NB];
   logic [31:0] m_tgt [NB];
   int          m_ptr;
   int          m_cnt [NH];

   function automatic int m_find(logic [31:0] pc);
      for (int i = 0; i < NB; i++)
         if (m_vld[i] && m_tag[i] == pc[31:2]) return i;
      return -1;
   endfunction

   function automatic logic m_dir(logic [31:0] pc);
      return m_cnt[pc[10:2]] >= 2;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < NB; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
      for (int i = 0; i < NH; i++) m_cnt[i] = 1;
      m_ptr = 0;
   endtask

   task automatic m_update(logic [31:0] pc, logic tk, logic [31:0] tg);
      int h;
      h = m_find(pc);
      if (tk) begin
         if (h >= 0) m_tgt[h] = tg;
         else begin
            m_vld[m_ptr] = 1'b1; m_tag[m_ptr] = pc[31:2]; m_tgt[m_ptr] = tg;
            m_ptr = (m_ptr + 1) % NB;
         end
         if (m_cnt[pc[10:2]] < 3) m_cnt[pc[10:2]]++;
      end else begin
         if (h >= 0) m_vld[h] = 1'b0;
         if (m_cnt[pc[10:2]] > 0) m_cnt[pc[10:2]]--;
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      upd_valid = 1'b0; dec_valid = 1'b0;
      repeat (3) @(posedge clk);
      m_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive at negedge, compare to model, then apply model update at the edge
   task automatic step(logic [31:0] fpc, logic dv, logic [31:0] dpc, logic dh,
                       logic [31:0] dt, logic uv, logic [31:0] upc, logic ut,
                       logic [31:0] utg, logic up);
      int h;
      logic ed;
      fetch_pc = fpc; dec_valid = dv; dec_pc = dpc; dec_btc_hit = dh; dec_target = dt;
      upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg; upd_pred_taken = up;
      #1ns;
      h = m_find(fpc);
      check("R2/R10 fetch_hit", 32'(fetch_hit), 32'(h >= 0));
      check(h >= 0 ? "R2 fetch_next_pc" : "R3 fetch_next_pc", fetch_next_pc,
            h >= 0 ? m_tgt[h] : fpc + 32'd4);
      check("R7 fetch_taken", 32'(fetch_taken), 32'(m_dir(fpc)));
      ed = m_dir(dpc);
      check("R6 dec_taken", 32'(dec_taken), 32'(ed));
      check("R8 dec_override", 32'(dec_override), 32'(dv && (ed != dh)));
      check("R8 dec_fix_pc", dec_fix_pc, ed ? dt : dpc + 32'd4);
      check("R9 upd_flush", 32'(upd_flush), 32'(uv && (up != ut)));
      @(posedge clk);
      if (uv) m_update(upc, ut, utg);
      @(negedge clk);
      upd_valid = 1'b0; dec_valid = 1'b0;
   endtask

   task automatic idle_fetch(logic [31:0] fpc, logic [31:0] dpc);
      step(fpc, 1'b1, dpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
   endtask

   function automatic logic [31:0] rnd_pc();
      logic [31:0] k;
      k = 32'($urandom % 96);
      return (($urandom % 3) == 0) ? 32'h8000_1000 + k * 4 : 32'h0000_1000 + k * 4;
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_reset();
      do_reset();

      // R1: nothing cached, counters weakly not taken
      #1ns;
      check("R1 no hit after reset", 32'(fetch_hit), 32'd0);
      check("R1 sequential after reset", fetch_next_pc, 32'h4);
      check("R1 counter weak not-taken", 32'(dec_taken), 32'd0);
      idle_fetch(32'h40, 32'h40);
      // R1/R6: one taken moves weak not-taken to weak taken
      step(32'h0, 1'b0, 32'h0, 1'b0, 0, 1'b1, 32'h40, 1'b1, 32'h900, 1'b0);
      #1ns; dec_pc = 32'h40; #1ns;
      check("R1 one taken from reset gives taken", 32'(dec_taken), 32'd1);

      // R10: same-cycle update and fetch sees old state
      step(32'h200, 1'b0, 0, 1'b0, 0, 1'b1, 32'h200, 1'b1, 32'h3000, 1'b0);
      #1ns; fetch_pc = 32'h200; #1ns;
      check("R10 hit after same-cycle update", 32'(fetch_hit), 32'd1);
      check("R2 target after update", fetch_next_pc, 32'h3000);
      // R4: taken hit rewrites target
      step(32'h200, 1'b0, 0, 1'b0, 0, 1'b1, 32'h200, 1'b1, 32'h5550, 1'b1);
      #1ns; fetch_pc = 32'h200; #1ns;
      check("R4 target rewritten", fetch_next_pc, 32'h5550);
      // R5: not taken drops the entry
      step(32'h200, 1'b0, 0, 1'b0, 0, 1'b1, 32'h200, 1'b0, 0, 1'b1);
      #1ns; fetch_pc = 32'h200; #1ns;
      check("R5 entry dropped", 32'(fetch_hit), 32'd0);

      // R6: saturation at 3 and 0
      for (int i = 0; i < 4; i++)
         step(32'h0, 1'b0, 0, 1'b0, 0, 1'b1, 32'h80, 1'b1, 32'h700, 1'b1);
      step(32'h0, 1'b0, 0, 1'b0, 0, 1'b1, 32'h80, 1'b0, 0, 1'b1);
      #1ns; dec_pc = 32'h80; #1ns;
      check("R6 saturated high survives one not-taken", 32'(dec_taken), 32'd1);
      for (int i = 0; i < 5; i++)
         step(32'h0, 1'b0, 0, 1'b0, 0, 1'b1, 32'h80, 1'b0, 0, 1'b0);
      step(32'h0, 1'b0, 0, 1'b0, 0, 1'b1, 32'h80, 1'b1, 32'h700, 1'b0);
      #1ns; dec_pc = 32'h80; #1ns;
      check("R6 saturated low needs two takens", 32'(dec_taken), 32'd0);
      // R6: aliasing index bits [10:2]
      #1ns; dec_pc = 32'h8000_0080; #1ns;
      check("R6 alias shares counter", 32'(dec_taken), 32'd0);

      // R4: round-robin fill and wrap evicts the oldest entry
      do_reset();
      for (int i = 0; i < NB + 1; i++)
         step(32'h0, 1'b0, 0, 1'b0, 0, 1'b1, 32'h4000 + 32'(i) * 4, 1'b1,
              32'h9000 + 32'(i) * 4, 1'b0);
      #1ns; fetch_pc = 32'h4000; #1ns;
      check("R4 first entry evicted on wrap", 32'(fetch_hit), 32'd0);
      #1ns; fetch_pc = 32'h4004; #1ns;
      check("R4 second entry kept", fetch_next_pc, 32'h9004);
      #1ns; fetch_pc = 32'h4000 + NB * 4; #1ns;
      check("R4 newest in slot 0", fetch_next_pc, 32'h9000 + NB * 4);

      // R8: decode override directed
      step(32'h0, 1'b1, 32'h4004, 1'b1, 32'h1234, 1'b0, 0, 1'b0, 0, 1'b0);

      // random mix against the model
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a;
         a = rnd_pc();
         step(rnd_pc(), 1'($urandom % 2), (($urandom % 2) == 0) ? a : rnd_pc(),
              1'($urandom % 2), 32'($urandom) & 32'hFFFF_FFFC,
              1'(($urandom % 4) != 0), a, 1'(($urandom % 3) != 0),
              32'($urandom) & 32'hFFFF_FFFC, 1'($urandom % 2));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule